// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds a small set of physical event counters behind a word-addressed register port. Each physical counter runs either as one 32-bit count or as two independent 16-bit halves, so the bank offers twice as many logical counters as physical ones. Software never writes a live count directly. A counter write lands in a per-counter holding latch, and the latched value moves into the live counter only when the control register is written with the monitor enable bit set.

A status register collects one pending bit per logical counter whenever that counter wraps from all-ones to zero. Reading it returns the pending bits and clears them in the same access. Writing it loads the interrupt enable mask. A single interrupt line is raised while any pending bit is enabled. All register data travels in the upper 32 bits of a 64-bit bus word. Read data returns one cycle after the read strobe, together with a valid flag.

Top module: `split_ctr_bank`

## Requirements
- R1: Control register (word address 0): bit 0 is the monitor enable, and bit 1+p puts physical counter p into split mode (1 = two 16-bit halves). It reads back as written.
- R2: Logical counter L is at word address 8+L and uses physical counter L mod 4. In split mode, L in 0..3 reads and writes the upper half and L in 4..7 reads and writes the lower half. A half write leaves the other half unchanged.
- R3: In 32-bit mode, L in 0..3 reads and writes the full 32-bit value, and L in 4..7 reads and writes only its low 16 bits. The event inputs of logical counters 4..7 have no effect on a counter in 32-bit mode.
- R4: A counter write changes only the holding latch, never the live count. While a latched value is uncommitted, a counter read returns the latch. Otherwise it returns the live count.
- R5: A control write with bit 0 set loads every uncommitted latch into its live counter, including when the monitor is already enabled. A control write with bit 0 clear commits nothing.
- R6: While enabled, each live counter, or each half in split mode, increments by one on every clock edge at which its event input is high. Each half wraps independently.
- R7: A wrap from all-ones to zero sets status bit L of the wrapping logical counter. No pending bit rises without such a wrap.
- R8: A status read (word address 1) returns the pending bits in bits 7:0 of the register value and clears them. A wrap in the same cycle as the read stays pending.
- R9: A status write loads the interrupt mask from bits 7:0. `irq` is high exactly when a pending bit is also enabled, so writing zero drops `irq` on the next cycle.
- R10: Register values sit in bus bits 63:32. Bits 31:0 are ignored on write and read as zero. `bus_rdata` and `bus_rvalid` appear on the cycle after `bus_rd`.
- R11: With the enable bit clear, all live counts hold their value.
- R12: Reset clears the counters, latches, control, mask and pending bits, and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 64 | Write data (value in bits 63:32) |
| bus_rdata | output | 64 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| evt_in | input | 8 | Event input per logical counter |
| irq | output | 1 | Monitor interrupt |

## Verification
A latch flag that is stuck or never cleared shows at the next counter read, which returns a stale latch in place of a moving count. It also shows after a commit, where a count fails to start from the written value. A wrong half-select or wrap carry shows in the very next read of the neighbouring logical counter, or as a pending bit on the wrong index once the status register is read. Pending and mask faults reach `irq` one cycle after the wrap, mask write or status read that should have moved it.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = REG_W / 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CTR
  } reg_sel_e;
endpackage

// File: rtl/scb_phys_ctr.sv
// One physical counter: holding latch, uncommitted flag, live count, wrap detect.
module scb_phys_ctr
  import scb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             split,
  input  logic             commit,
  input  logic             wr,
  input  logic             wr_upper,
  input  logic [REG_W-1:0] wr_val,
  input  logic             evt_hi,
  input  logic             evt_lo,
  output logic [REG_W-1:0] view,
  output logic [REG_W-1:0] live_o,
  output logic             wrap_hi,
  output logic             wrap_lo
);
  logic [REG_W-1:0]  live_q, live_d;
  logic [REG_W-1:0]  latch_q, latch_d;
  logic              held_q, held_d;
  logic              live_ce, latch_ce;
  logic [HALF_W-1:0] hi_q, lo_q;

  assign hi_q   = live_q[REG_W-1:HALF_W];
  assign lo_q   = live_q[HALF_W-1:0];
  assign view   = held_q ? latch_q : live_q;
  assign live_o = live_q;

  // latch path
  always_comb begin
    latch_d = latch_q;
    held_d  = held_q;
    if (wr) begin
      if (wr_upper && !split) latch_d = wr_val;
      else if (wr_upper)      latch_d = {wr_val[HALF_W-1:0], view[HALF_W-1:0]};
      else                    latch_d = {view[REG_W-1:HALF_W], wr_val[HALF_W-1:0]};
      held_d = 1'b1;
    end else if (commit) begin
      held_d = 1'b0;
    end
  end

  // live path: commit wins over counting
  always_comb begin
    live_d  = live_q;
    wrap_hi = 1'b0;
    wrap_lo = 1'b0;
    if (commit) begin
      if (held_q) live_d = latch_q;
    end else if (en) begin
      if (split) begin
        if (evt_hi) begin
          live_d[REG_W-1:HALF_W] = hi_q + 1'b1;
          wrap_hi = &hi_q;
        end
        if (evt_lo) begin
          live_d[HALF_W-1:0] = lo_q + 1'b1;
          wrap_lo = &lo_q;
        end
      end else if (evt_hi) begin
        live_d  = live_q + 1'b1;
        wrap_hi = &live_q;
      end
    end
  end

  assign live_ce  = commit | en;
  assign latch_ce = wr | commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      latch_q <= '0;
      held_q  <= 1'b0;
    end else begin
      if (live_ce)  live_q  <= live_d;
      if (wr)       latch_q <= latch_d;
      if (latch_ce) held_q  <= held_d;
    end
  end
endmodule

// File: rtl/scb_status.sv
// Pending bits (clear on read, set on wrap), interrupt mask, interrupt line.
module scb_status #(
  parameter int unsigned NLOG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_clr,
  input  logic            mask_wr,
  input  logic [NLOG-1:0] mask_val,
  input  logic [NLOG-1:0] wraps,
  output logic [NLOG-1:0] pend,
  output logic [NLOG-1:0] mask,
  output logic            irq
);
  logic [NLOG-1:0] pend_q, pend_d, mask_q, mask_d;

  always_comb begin
    pend_d = (rd_clr ? '0 : pend_q) | wraps;
    mask_d = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = |(pend_q & mask_q);
endmodule

// File: rtl/split_ctr_bank.sv
// Top: register decode, control register, counter array, read-data register.
module split_ctr_bank
  import scb_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic                    bus_rvalid,
  input  logic [2*NUM_PHYS-1:0]   evt_in,
  output logic                    irq
);
  localparam int unsigned NLOG   = 2 * NUM_PHYS;
  localparam int unsigned LIDX_W = $clog2(NLOG);
  localparam int unsigned PIDX_W = $clog2(NUM_PHYS);
  localparam int unsigned CTRL_W = 1 + NUM_PHYS;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  reg_sel_e              sel;
  logic [REG_W-1:0]      wval;
  logic [LIDX_W-1:0]     lidx;
  logic [PIDX_W-1:0]     pidx;
  logic                  upper;
  logic [CTRL_W-1:0]     ctrl_q, ctrl_d;
  logic                  ctrl_wr, commit, en;
  logic [NUM_PHYS-1:0]   split;
  logic [NUM_PHYS-1:0]   wrap_hi, wrap_lo;
  logic [NLOG-1:0]       wraps, pend, mask;
  logic [REG_W-1:0]      view [NUM_PHYS];
  logic [NUM_PHYS*REG_W-1:0] live_vec;
  logic [REG_W-1:0]      rd_val;
  logic [BUS_W-1:0]      rdata_q, rdata_d;
  logic                  rvalid_q;

  // decode
  always_comb begin
    if (bus_addr[ADDR_W-1])     sel = SEL_CTR;
    else if (bus_addr == A_CTRL) sel = SEL_CTRL;
    else if (bus_addr == A_STAT) sel = SEL_STAT;
    else                         sel = SEL_NONE;
  end

  assign wval  = bus_wdata[BUS_W-1 -: REG_W];
  assign lidx  = bus_addr[LIDX_W-1:0];
  assign pidx  = lidx[PIDX_W-1:0];
  assign upper = !lidx[LIDX_W-1];

  // control register
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign commit  = ctrl_wr && wval[0];
  assign ctrl_d  = wval[CTRL_W-1:0];
  assign en      = ctrl_q[0];
  assign split   = ctrl_q[CTRL_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  // counter array
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
    logic wr_p;
    assign wr_p = bus_wr && (sel == SEL_CTR) && (pidx == PIDX_W'(p));

    scb_phys_ctr u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .split    (split[p]),
      .commit   (commit),
      .wr       (wr_p),
      .wr_upper (upper),
      .wr_val   (wval),
      .evt_hi   (evt_in[p]),
      .evt_lo   (evt_in[p+NUM_PHYS]),
      .view     (view[p]),
      .live_o   (live_vec[p*REG_W +: REG_W]),
      .wrap_hi  (wrap_hi[p]),
      .wrap_lo  (wrap_lo[p])
    );
  end

  assign wraps = {wrap_lo, wrap_hi};

  scb_status #(.NLOG(NLOG)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_clr   (bus_rd && (sel == SEL_STAT)),
    .mask_wr  (bus_wr && (sel == SEL_STAT)),
    .mask_val (wval[NLOG-1:0]),
    .wraps    (wraps),
    .pend     (pend),
    .mask     (mask),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    logic [REG_W-1:0] v;
    v = view[pidx];
    rd_val = '0;
    unique case (sel)
      SEL_CTRL: rd_val = REG_W'(ctrl_q);
      SEL_STAT: rd_val = REG_W'(pend);
      SEL_CTR: begin
        if (!upper)          rd_val = REG_W'(v[HALF_W-1:0]);
        else if (split[pidx]) rd_val = REG_W'(v[REG_W-1:HALF_W]);
        else                  rd_val = v;
      end
      default:  rd_val = '0;
    endcase
  end

  assign rdata_d = {rd_val, {(BUS_W-REG_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/scb_chk.sv
module scb_chk #(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [63:0]               bus_wdata,
  input logic [63:0]               bus_rdata,
  input logic                      bus_rvalid,
  input logic                      irq,
  input logic                      en,
  input logic [2*NUM_PHYS-1:0]     wraps,
  input logic [2*NUM_PHYS-1:0]     pend,
  input logic [NUM_PHYS*32-1:0]    live_vec
);
  localparam int unsigned NLOG = 2 * NUM_PHYS;

  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[31:0] == 32'h0)); // R10

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1)) |=> ((pend & ~$past(wraps)) == '0)); // R8

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_wr) |=> $stable(live_vec)); // R11

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && bus_wr && bus_addr[ADDR_W-1]) |=> $stable(live_vec)); // R4

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[32 +: NLOG] == '0) |=> !irq); // R9

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend)); // R9

  AST_PEND_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wraps == '0) |=> ((pend & ~$past(pend)) == '0)); // R7
endmodule

bind split_ctr_bank scb_chk #(.NUM_PHYS(NUM_PHYS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .en         (ctrl_q[0]),
  .wraps      (wraps),
  .pend       (pend),
  .live_vec   (live_vec)
);

// File: tb/tb_split_ctr_bank.sv
module tb_split_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  evt_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [63:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  split_ctr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_in(evt_in), .irq(irq)
  );

  // monitor: pops expected read data as it appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (bus_rdata !== e.v) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {v, 32'hDEAD_BEEF};
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.v = {e, 32'h0}; x.tag = tag;
    sb.push_back(x);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    evt_in = m;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk_irq(1'b0, "R12 irq after reset");
    reg_rd(4'h0, 32'h0, "R12 ctrl reset");
    reg_rd(4'h1, 32'h0, "R12 status reset");
    reg_rd(4'h8, 32'h0, "R12 counter reset");

    // R4 write goes to latch; events while disabled ignored (R11)
    reg_wr(4'h8, 32'h1234_5678);
    reg_rd(4'h8, 32'h1234_5678, "R4 latched value read");
    pulse(8'h01, 5);
    reg_wr(4'h0, 32'h1);                 // enable + commit (R5)
    reg_rd(4'h8, 32'h1234_5678, "R5 commit on enable");
    pulse(8'h01, 10);
    reg_rd(4'h8, 32'h1234_5682, "R6 32-bit count");

    // R11 freeze
    reg_wr(4'h0, 32'h0);
    pulse(8'h01, 7);
    reg_rd(4'h8, 32'h1234_5682, "R11 frozen when disabled");

    // split mode on physical counter 1 (R1 bit 2)
    reg_wr(4'h0, 32'h4);
    reg_wr(4'h9, 32'h0000_FFFE);
    reg_wr(4'hD, 32'h0000_0003);
    reg_rd(4'h9, 32'h0000_FFFE, "R2 upper half latch");
    reg_rd(4'hD, 32'h0000_0003, "R2 lower half latch");
    reg_wr(4'h0, 32'h5);
    pulse(8'h22, 2);
    pulse(8'h02, 1);
    reg_rd(4'h9, 32'h0000_0001, "R6 upper half wraps");
    reg_rd(4'hD, 32'h0000_0005, "R6 lower half independent");
    chk_irq(1'b0, "R9 masked pending");
    reg_wr(4'h1, 32'h02);
    chk_irq(1'b1, "R9 enabled pending raises irq");
    reg_rd(4'h1, 32'h02, "R7 pending bit 1");
    chk_irq(1'b0, "R8 read clears");
    reg_rd(4'h1, 32'h0, "R8 status cleared");

    // R3 32-bit mode, logical 6 = low 16 of physical 2; write while enabled stays latched (R4)
    reg_wr(4'hA, 32'hAAAA_5555);
    reg_rd(4'hA, 32'hAAAA_5555, "R4 latch while enabled");
    reg_wr(4'hE, 32'h0000_1234);
    reg_rd(4'hE, 32'h0000_1234, "R3 low half read");
    reg_rd(4'hA, 32'hAAAA_1234, "R3 low half merged");
    reg_wr(4'h0, 32'h5);                 // re-commit while enabled (R5)
    evt_in = 8'h44;
    @(negedge clk);
    evt_in = 8'h40;
    repeat (3) @(negedge clk);
    evt_in = 8'h00;
    reg_rd(4'hA, 32'hAAAA_1235, "R3 high-index event ignored in 32-bit mode");

    // 32-bit wrap on physical 3
    reg_wr(4'hB, 32'hFFFF_FFFF);
    reg_wr(4'h0, 32'h5);
    pulse(8'h08, 2);
    reg_rd(4'hB, 32'h0000_0001, "R6 32-bit wrap");
    reg_rd(4'hF, 32'h0000_0001, "R3 logical 7 low half");
    reg_wr(4'h1, 32'h08);
    chk_irq(1'b1, "R9 irq on bit 3");
    reg_wr(4'h1, 32'h00);
    chk_irq(1'b0, "R9 zero mask disables");
    reg_rd(4'h1, 32'h08, "R8 pending survives mask change");
    reg_rd(4'h1, 32'h00, "R8 cleared after read");
    reg_rd(4'h0, 32'h5, "R1 R10 control readback, low half zero");

    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10 missing read data: actual %0d outstanding expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule